// File: doc/BRIEF.md
# Write Burst Strobe and Data Launch Scheduler

This block sits behind the command encoder of a double-data-rate memory controller. When a write command goes out, it captures the write latency, the burst length, the complementary-strobe setting and up to eight beats of write data and byte masks. It then produces, one clock cycle at a time, the drive enables and values for the data strobe, the inverted strobe, the data lanes and the mask lanes. Each output comes as a pair, one value for the high half of the clock and one for the low half, so a double-rate output stage can serialize the pair.

The strobe starts the configured number of cycles after the command. It is low in the first half-slot and then toggles every half-slot. It stays driven for one half-slot after the last data beat, then releases. Data beats sit in the same half-slots as the strobe edges. A separate phase-select output tells the output stage to launch them from a quarter-cycle-shifted clock, which centres each beat between strobe edges. Only one burst is handled at a time. A request that arrives during a burst is dropped.

Top module: `wr_burst_sched`

## Requirements
- R1: During and after reset, `busy` and every output enable are low and every value output is zero.
- R2: A request (`wr_req` high at a rising edge) with `busy` low is accepted, and `busy` is high from the next cycle until the burst completes. A request that arrives while `busy` is high is ignored and leaves the burst in progress unchanged.
- R3: Cycle index j counts clock cycles after the accepting edge, starting from 0. The first cycle in which the strobe is driven has index j = `wr_lat`, and no output enable is high before it. A `wr_lat` of 0 is legal.
- R4: The strobe value is 0 in every high-half slot and 1 in every low-half slot. It is driven in exactly BL+1 half-slots. These are BL/2 cycles with both halves enabled, then one postamble cycle with only the high half enabled.
- R5: Beat b is carried in half-slot b, where window cycle k holds beat 2k in its high half and beat 2k+1 in its low half. Beat b takes data `wdata[b*DQ_W +: DQ_W]` and mask `wmask[b*DM_W +: DM_W]`, so the lowest slice goes first.
- R6: The data and mask enables are high in exactly the first BL half-slots, and low in the postamble slot. `dq_quarter` is high in exactly the cycles in which a data enable is high. Value outputs are zero whenever their enable is low.
- R7: When `cdqs_en` was high at acceptance, the inverted strobe enables equal the strobe enables and its values are the inverse of the strobe values. When it was low, the inverted strobe enables and values stay low for the whole burst.
- R8: `bl8` = 1 selects BL = 8 and `bl8` = 0 selects BL = 4.
- R9: `busy` falls at the edge that ends the postamble cycle. A request presented in the cycle right after that is accepted.
- R10: Latency, burst length, strobe mode, data and mask are captured at acceptance. Changes to those inputs during a burst have no effect on the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_req | input | 1 | Write burst request |
| wr_lat | input | WL_W | Write latency in clock cycles |
| bl8 | input | 1 | 1: eight beats, 0: four beats |
| cdqs_en | input | 1 | Enable complementary strobe |
| wdata | input | 8*DQ_W | Packed beat data, beat 0 lowest |
| wmask | input | 8*DM_W | Packed beat masks, beat 0 lowest |
| busy | output | 1 | Burst in progress |
| dqs_oe_r | output | 1 | Strobe enable, high half |
| dqs_oe_f | output | 1 | Strobe enable, low half |
| dqs_r | output | 1 | Strobe value, high half |
| dqs_f | output | 1 | Strobe value, low half |
| dqsn_oe_r | output | 1 | Inverted strobe enable, high half |
| dqsn_oe_f | output | 1 | Inverted strobe enable, low half |
| dqsn_r | output | 1 | Inverted strobe value, high half |
| dqsn_f | output | 1 | Inverted strobe value, low half |
| dq_oe_r | output | 1 | Data and mask enable, high half |
| dq_oe_f | output | 1 | Data and mask enable, low half |
| dq_r | output | DQ_W | Data, high half |
| dq_f | output | DQ_W | Data, low half |
| dm_r | output | DM_W | Mask, high half |
| dm_f | output | DM_W | Mask, low half |
| dq_quarter | output | 1 | Launch data from the quarter-cycle clock |

## Verification
The bench builds the block with DQ_W = 8, so each beat is one byte with one mask bit and every slice can hold a distinct value. Beat order and mask position are therefore visible in every half-slot. The default 4-bit WL_W lets the bench test latency 0, where the window opens in the first cycle after acceptance, as well as the largest latency of 15. A request is also presented the cycle after release to test back-to-back acceptance. A refused request is presented mid-burst with different latency, data and mask, to show that the captured values are the ones used.

// File: rtl/wr_burst_sched.sv
module wr_burst_sched #(
  parameter int DQ_W = 16,
  parameter int WL_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_req,
  input  logic [WL_W-1:0]     wr_lat,
  input  logic                bl8,
  input  logic                cdqs_en,
  input  logic [8*DQ_W-1:0]   wdata,
  input  logic [8*DQ_W/8-1:0] wmask,
  output logic                busy,
  output logic                dqs_oe_r,
  output logic                dqs_oe_f,
  output logic                dqs_r,
  output logic                dqs_f,
  output logic                dqsn_oe_r,
  output logic                dqsn_oe_f,
  output logic                dqsn_r,
  output logic                dqsn_f,
  output logic                dq_oe_r,
  output logic                dq_oe_f,
  output logic [DQ_W-1:0]     dq_r,
  output logic [DQ_W-1:0]     dq_f,
  output logic [DQ_W/8-1:0]   dm_r,
  output logic [DQ_W/8-1:0]   dm_f,
  output logic                dq_quarter
);
  localparam int DM_W  = DQ_W / 8;
  localparam int CNT_W = WL_W + 1;
  localparam int SL_W  = CNT_W + 1;

  logic                active, bl8_q, cdqs_q;
  logic [WL_W-1:0]     wl_q;
  logic [CNT_W-1:0]    cnt;
  logic [8*DQ_W-1:0]   wd_q;
  logic [8*DM_W-1:0]   wm_q;

  logic [CNT_W-1:0] half, pos;
  logic [SL_W-1:0]  beats, slot_r, slot_f;
  logic             in_win, last;

  assign half   = bl8_q ? CNT_W'(4) : CNT_W'(2);
  assign beats  = bl8_q ? SL_W'(8) : SL_W'(4);
  assign last   = active && (cnt == CNT_W'(wl_q) + half);
  assign in_win = active && (cnt >= CNT_W'(wl_q));
  assign pos    = cnt - CNT_W'(wl_q);
  assign slot_r = {pos, 1'b0};
  assign slot_f = {pos, 1'b1};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      wl_q   <= '0;
      bl8_q  <= 1'b0;
      cdqs_q <= 1'b0;
      wd_q   <= '0;
      wm_q   <= '0;
    end else if (!active) begin
      if (wr_req) begin
        active <= 1'b1;
        cnt    <= '0;
        wl_q   <= wr_lat;
        bl8_q  <= bl8;
        cdqs_q <= cdqs_en;
        wd_q   <= wdata;
        wm_q   <= wmask;
      end
    end else if (last) begin
      active <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign busy      = active;
  assign dqs_oe_r  = in_win && (slot_r <= beats);
  assign dqs_oe_f  = in_win && (slot_f <= beats);
  assign dqs_r     = 1'b0;
  assign dqs_f     = dqs_oe_f;
  assign dqsn_oe_r = dqs_oe_r && cdqs_q;
  assign dqsn_oe_f = dqs_oe_f && cdqs_q;
  assign dqsn_r    = dqsn_oe_r && !dqs_r;
  assign dqsn_f    = dqsn_oe_f && !dqs_f;
  assign dq_oe_r   = in_win && (slot_r < beats);
  assign dq_oe_f   = in_win && (slot_f < beats);
  assign dq_r      = dq_oe_r ? wd_q[slot_r[2:0]*DQ_W +: DQ_W] : '0;
  assign dq_f      = dq_oe_f ? wd_q[slot_f[2:0]*DQ_W +: DQ_W] : '0;
  assign dm_r      = dq_oe_r ? wm_q[slot_r[2:0]*DM_W +: DM_W] : '0;
  assign dm_f      = dq_oe_f ? wm_q[slot_f[2:0]*DM_W +: DM_W] : '0;
  assign dq_quarter = dq_oe_r || dq_oe_f;

  a_r6_data_inside_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe_r |-> dqs_oe_r) and (dq_oe_f |-> dqs_oe_f));
  a_r4_preamble_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dqs_oe_r) |-> (!dqs_r && dqs_oe_f && dq_oe_r));
  a_r4_postamble_half: assert property (@(posedge clk) disable iff (!rst_n)
    (dqs_oe_r && !dq_oe_r) |-> (!dqs_oe_f && last));
  a_r9_release_after_post: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(dqs_oe_r && !dq_oe_r));
  a_r2_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> busy);
  a_r7_pair_opposite: assert property (@(posedge clk) disable iff (!rst_n)
    dqsn_oe_f |-> (dqs_oe_f && (dqsn_f != dqs_f)));
  a_r10_latency_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(wl_q) && $stable(wd_q)));
endmodule

// File: tb/test_wr_burst_sched.sv
`timescale 1ns/1ps
module test_wr_burst_sched;
  localparam int DQ_W = 8;
  localparam int DM_W = 1;
  localparam int WL_W = 4;

  typedef struct packed {
    logic busy, dqs_oe_r, dqs_oe_f, dqs_r, dqs_f;
    logic dqsn_oe_r, dqsn_oe_f, dqsn_r, dqsn_f;
    logic dq_oe_r, dq_oe_f;
    logic [DQ_W-1:0] dq_r, dq_f;
    logic [DM_W-1:0] dm_r, dm_f;
    logic quarter;
  } rec_t;

  logic clk = 0, rst_n = 0, wr_req = 0, bl8 = 0, cdqs_en = 0;
  logic [WL_W-1:0] wr_lat = '0;
  logic [8*DQ_W-1:0] wdata = '0;
  logic [8*DM_W-1:0] wmask = '0;
  rec_t act;

  wr_burst_sched #(.DQ_W(DQ_W), .WL_W(WL_W)) i_wr_burst_sched (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_lat(wr_lat), .bl8(bl8),
    .cdqs_en(cdqs_en), .wdata(wdata), .wmask(wmask), .busy(act.busy),
    .dqs_oe_r(act.dqs_oe_r), .dqs_oe_f(act.dqs_oe_f), .dqs_r(act.dqs_r), .dqs_f(act.dqs_f),
    .dqsn_oe_r(act.dqsn_oe_r), .dqsn_oe_f(act.dqsn_oe_f), .dqsn_r(act.dqsn_r), .dqsn_f(act.dqsn_f),
    .dq_oe_r(act.dq_oe_r), .dq_oe_f(act.dq_oe_f), .dq_r(act.dq_r), .dq_f(act.dq_f),
    .dm_r(act.dm_r), .dm_f(act.dm_f), .dq_quarter(act.quarter));

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  bit mon_on = 0, done = 0;
  rec_t exp_q[$];
  string tag_q[$];

  task automatic check(input rec_t e, input string tag);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, e);
    end
  endtask

  // R3 R4 R5 R6 R7 R8: expected per-cycle records for one accepted burst
  task automatic push_burst(input int wl, input bit b8, input bit cen,
                            input logic [8*DQ_W-1:0] d, input logic [8*DM_W-1:0] m);
    int bl = b8 ? 8 : 4;
    for (int j = 0; j < wl; j++) begin
      rec_t r = '0;
      r.busy = 1;
      exp_q.push_back(r); tag_q.push_back("R3 latency wait");
    end
    for (int k = 0; k <= bl/2; k++) begin
      rec_t r = '0;
      int sr = 2*k, sf = 2*k+1;
      r.busy = 1;
      r.dqs_oe_r = (sr <= bl);
      r.dqs_oe_f = (sf <= bl);
      r.dqs_r = 0;
      r.dqs_f = r.dqs_oe_f;
      r.dqsn_oe_r = cen && r.dqs_oe_r;
      r.dqsn_oe_f = cen && r.dqs_oe_f;
      r.dqsn_r = r.dqsn_oe_r;
      r.dqsn_f = 0;
      r.dq_oe_r = (sr < bl);
      r.dq_oe_f = (sf < bl);
      if (r.dq_oe_r) begin r.dq_r = d[sr*DQ_W +: DQ_W]; r.dm_r = m[sr*DM_W +: DM_W]; end
      if (r.dq_oe_f) begin r.dq_f = d[sf*DQ_W +: DQ_W]; r.dm_f = m[sf*DM_W +: DM_W]; end
      r.quarter = r.dq_oe_r || r.dq_oe_f;
      exp_q.push_back(r);
      tag_q.push_back(k == bl/2 ? "R4 postamble" : "R5 R6 R7 beat window");
    end
  endtask

  task automatic send(input int wl, input bit b8, input bit cen,
                      input logic [8*DQ_W-1:0] d, input logic [8*DM_W-1:0] m, input bit accept);
    @(negedge clk);
    wr_req = 1; wr_lat = WL_W'(wl); bl8 = b8; cdqs_en = cen; wdata = d; wmask = m;
    @(posedge clk);
    if (accept) push_burst(wl, b8, cen, d, m);
    @(negedge clk);
    wr_req = 0;
  endtask

  task automatic wait_idle();
    while (exp_q.size() != 0) @(posedge clk);
  endtask

  // monitor: compare once per cycle at the falling edge
  always @(negedge clk) begin
    if (mon_on && rst_n) begin
      if (exp_q.size() != 0) check(exp_q.pop_front(), tag_q.pop_front());
      else check('0, "R2 R9 idle");
    end
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    wr_req = 1; wr_lat = 4'd2; bl8 = 1; cdqs_en = 1; wdata = '1; wmask = '1;
    repeat (3) @(posedge clk);
    #1 check('0, "R1 in reset");
    @(negedge clk);
    rst_n = 1; wr_req = 0;
    mon_on = 1;
    repeat (2) @(negedge clk);
    check('0, "R1 after reset");

    // R3 R4 R5 R6 R7: four beats, latency 3, complementary strobe on
    send(3, 0, 1, 64'h0000_0000_d4c3_b2a1, 8'b0000_0101, 1);
    wait_idle();
    // R8 R3 R7: eight beats, zero latency, complementary strobe off
    send(0, 1, 0, 64'h8877_6655_4433_2211, 8'b1010_0110, 1);
    wait_idle();
    // R3: largest latency, eight beats
    send(15, 1, 1, 64'hf0e1_d2c3_b4a5_9687, 8'b1100_0011, 1);
    // R2 R10: refused request with new settings mid-burst
    repeat (4) @(negedge clk);
    send(1, 0, 0, 64'h5555_5555_5555_5555, 8'hff, 0);
    wait_idle();
    // R9: back-to-back acceptance right after release
    send(1, 0, 0, 64'h0102_0304_0506_0708, 8'b0000_1001, 1);
    wait_idle();
    send(2, 1, 1, 64'hdead_beef_cafe_f00d, 8'b0111_1110, 1);
    // R10: inputs change during the burst without a request
    @(negedge clk);
    wr_lat = 4'd9; bl8 = 0; cdqs_en = 0; wdata = '0; wmask = '0;
    wait_idle();
    repeat (3) @(negedge clk);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule